// File: doc/BRIEF.md
# Transceiver Power-Up Sequencer

This block brings a full-speed USB device core out of power-down in a fixed, safe order. After a start request it first turns on the register-side clock and lets the core's own reset go. It then switches on the transceiver's voltage references and waits for a programmable number of timebase ticks. The transceiver is not trusted while that wait runs. When the wait ends, the sequencer drops the forced USB reset. It then pulses a clear of the interrupt status, so that flags raised while the analog part was settling are thrown away. The 48 MHz protocol clock is switched on only as the last step.

The reference supplies and the clock generators are outside this block. Each one is controlled here by a plain level output. A `done` flag stays high once every step has been taken. Only the system reset returns the sequencer to its starting point. The system reset is asserted asynchronously and released synchronously inside the block.

Top module: `xcvr_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and after its release until a start is taken, `reg_clk_en`=0, `core_rst_n`=0, `xcvr_pdn`=1, `usb_force_rst`=1, `irq_clr`=0, `proto_clk_en`=0 and `done`=0.
- R2: A `start_req` sampled high at a clock edge while idle raises `reg_clk_en` and `core_rst_n` from the next cycle. All other outputs keep their reset values during that cycle.
- R3: One cycle after `reg_clk_en` rises, `xcvr_pdn` goes to 0. `usb_force_rst` stays at 1.
- R4: After `xcvr_pdn` falls, `usb_force_rst` stays at 1 until `startup_cnt` ticks have been counted. A tick is counted only at a clock edge where `tick`=1, and only after the cycle in which `xcvr_pdn` first reads 0. A tick seen in any earlier cycle is not counted. `usb_force_rst` falls one cycle after the edge at which the remaining count is already zero.
- R5: A `startup_cnt` of 0 releases `usb_force_rst` two cycles after `xcvr_pdn` falls, whatever `tick` does.
- R6: `irq_clr` is high for exactly one cycle. That cycle directly follows the first cycle in which `usb_force_rst` is 0, and `proto_clk_en` is still 0 during it.
- R7: `proto_clk_en` rises in the cycle right after the `irq_clr` pulse. `done` rises one cycle later.
- R8: Once high, `done` and every enable keep their values until reset. A `start_req` during the sequence or after it has no effect on any output.
- R9: Asserting `rst_n` mid-sequence returns all outputs to their R1 values at once, without waiting for a clock edge.
- R10: `startup_cnt` is sampled once, in the cycle in which `xcvr_pdn` first reads 0. Changing it later does not alter the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start_req | input | 1 | Request to begin the power-up order |
| tick | input | 1 | Timebase strobe that paces the startup wait |
| startup_cnt | input | CNT_W | Startup wait length in ticks |
| reg_clk_en | output | 1 | Register interface clock enable |
| core_rst_n | output | 1 | Core-specific reset, active low |
| xcvr_pdn | output | 1 | Transceiver reference power-down, active high |
| usb_force_rst | output | 1 | Forced USB reset, active high |
| irq_clr | output | 1 | One-cycle clear of the interrupt status |
| proto_clk_en | output | 1 | 48 MHz protocol clock enable |
| done | output | 1 | All steps completed |

## Verification
The bench builds the block with `CNT_W` = 8 and `SYNC_STAGES` = 2. This keeps every wait short, so the bench can follow each one cycle by cycle against a tick-count model. It exercises counts of 0, 1, 5 and 12 under dense, sparse and alternating tick patterns. The short waits also let it assert reset in the middle of a wait, and change `startup_cnt` or raise `start_req` while a wait is running, and still observe the whole release order.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLKON  = 3'd1,
    ST_REFON  = 3'd2,
    ST_SETTLE = 3'd3,
    ST_UNRST  = 3'd4,
    ST_FLUSH  = 3'd5,
    ST_PCLK   = 3'd6,
    ST_READY  = 3'd7
  } seq_state_t;

endpackage

// File: rtl/pwrseq_rst_sync.sv
module pwrseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[0] <= 1'b0;
          else         chain_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             count_en,
  input  logic             tick,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_we;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_we = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_we = 1'b1;
      cnt_d  = load_val;
    end else if (count_en && tick && !at_zero) begin
      cnt_we = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign expired = at_zero;

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic wait_over,
  output logic timer_load,
  output logic timer_run,
  output logic reg_clk_en,
  output logic core_rst_n,
  output logic xcvr_pdn,
  output logic usb_force_rst,
  output logic irq_clr,
  output logic proto_clk_en,
  output logic done
);

  seq_state_t state_q;
  seq_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_req) state_d = ST_CLKON;
      ST_CLKON:  state_d = ST_REFON;
      ST_REFON:  state_d = ST_SETTLE;
      ST_SETTLE: if (wait_over) state_d = ST_UNRST;
      ST_UNRST:  state_d = ST_FLUSH;
      ST_FLUSH:  state_d = ST_PCLK;
      ST_PCLK:   state_d = ST_READY;
      ST_READY:  state_d = ST_READY;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    reg_clk_en    = (state_q != ST_IDLE);
    core_rst_n    = (state_q != ST_IDLE);
    xcvr_pdn      = (state_q == ST_IDLE) || (state_q == ST_CLKON);
    usb_force_rst = (state_q == ST_IDLE) || (state_q == ST_CLKON) ||
                    (state_q == ST_REFON) || (state_q == ST_SETTLE);
    irq_clr       = (state_q == ST_FLUSH);
    proto_clk_en  = (state_q == ST_PCLK) || (state_q == ST_READY);
    done          = (state_q == ST_READY);
    timer_load    = (state_q == ST_REFON);
    timer_run     = (state_q == ST_SETTLE);
  end

endmodule

// File: rtl/xcvr_pwrup_seq.sv
module xcvr_pwrup_seq #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             tick,
  input  logic [CNT_W-1:0] startup_cnt,
  output logic             reg_clk_en,
  output logic             core_rst_n,
  output logic             xcvr_pdn,
  output logic             usb_force_rst,
  output logic             irq_clr,
  output logic             proto_clk_en,
  output logic             done
);

  logic srst_n;
  logic timer_load;
  logic timer_run;
  logic wait_over;

  pwrseq_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pwrseq_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (timer_load),
    .load_val (startup_cnt),
    .count_en (timer_run),
    .tick     (tick),
    .expired  (wait_over)
  );

  pwrseq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (srst_n),
    .start_req     (start_req),
    .wait_over     (wait_over),
    .timer_load    (timer_load),
    .timer_run     (timer_run),
    .reg_clk_en    (reg_clk_en),
    .core_rst_n    (core_rst_n),
    .xcvr_pdn      (xcvr_pdn),
    .usb_force_rst (usb_force_rst),
    .irq_clr       (irq_clr),
    .proto_clk_en  (proto_clk_en),
    .done          (done)
  );

endmodule

// File: rtl/xcvr_pwrup_seq_chk.sv
module xcvr_pwrup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_clk_en,
  input logic core_rst_n,
  input logic xcvr_pdn,
  input logic usb_force_rst,
  input logic irq_clr,
  input logic proto_clk_en,
  input logic done
);

  assert_clk_before_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_pdn |-> (reg_clk_en && core_rst_n));

  assert_ref_before_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !usb_force_rst |-> !xcvr_pdn);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq_clr);

  assert_flush_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> (!usb_force_rst && !proto_clk_en));

  assert_pclk_after_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_clk_en) |-> $past(irq_clr));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && proto_clk_en));

  assert_pclk_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_clk_en |=> proto_clk_en);

endmodule

bind xcvr_pwrup_seq xcvr_pwrup_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_clk_en    (reg_clk_en),
  .core_rst_n    (core_rst_n),
  .xcvr_pdn      (xcvr_pdn),
  .usb_force_rst (usb_force_rst),
  .irq_clr       (irq_clr),
  .proto_clk_en  (proto_clk_en),
  .done          (done)
);

// File: tb/xcvr_pwrup_seq_tb.sv
module xcvr_pwrup_seq_tb;

  localparam int CNT_W = 8;

  logic             clk;
  logic             rst_n;
  logic             start_req;
  logic             tick;
  logic [CNT_W-1:0] startup_cnt;
  logic             reg_clk_en;
  logic             core_rst_n;
  logic             xcvr_pdn;
  logic             usb_force_rst;
  logic             irq_clr;
  logic             proto_clk_en;
  logic             done;

  int checks;
  int errors;
  int cycles;

  xcvr_pwrup_seq #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_req     (start_req),
    .tick          (tick),
    .startup_cnt   (startup_cnt),
    .reg_clk_en    (reg_clk_en),
    .core_rst_n    (core_rst_n),
    .xcvr_pdn      (xcvr_pdn),
    .usb_force_rst (usb_force_rst),
    .irq_clr       (irq_clr),
    .proto_clk_en  (proto_clk_en),
    .done          (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {reg_clk_en, core_rst_n, xcvr_pdn, usb_force_rst,
            irq_clr, proto_clk_en, done};
  endfunction

  localparam int RESET_OUTS = 7'b0011000;

  task automatic t_reset();
    rst_n     = 1'b0;
    start_req = 1'b0;
    tick      = 1'b0;
    repeat (3) @(negedge clk);
    check(outs() == RESET_OUTS, "R1 during reset", outs(), RESET_OUTS);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(outs() == RESET_OUTS, "R1 after release", outs(), RESET_OUTS);
  endtask

  // mode 0: tick every cycle, 1: every third cycle, 2: alternating
  task automatic t_sequence(input int n, input int mode, input bit noise);
    int rem;
    bit released;
    int k;
    startup_cnt = n[CNT_W-1:0];
    tick = 1'b1;
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    check(outs() == 7'b1111000, "R2 clock and core reset first", outs(), 7'b1111000);
    @(negedge clk);
    check(outs() == 7'b1101000, "R3 reference power on", outs(), 7'b1101000);
    tick = 1'b1;
    @(posedge clk);
    rem = n;
    released = 1'b0;
    k = 0;
    for (int guard = 0; guard < 400; guard++) begin
      @(negedge clk);
      startup_cnt = n[CNT_W-1:0] ^ 8'h5A;
      if (noise) start_req = 1'b1;
      check(usb_force_rst == !released, "R4 R5 R10 forced reset timing",
            usb_force_rst, !released);
      if (released) break;
      case (mode)
        0:       tick = 1'b1;
        1:       tick = (k % 3 == 2);
        default: tick = k[0];
      endcase
      k++;
      @(posedge clk);
      if (rem == 0) released = 1'b1;
      else if (tick) rem--;
    end
    check(outs() == 7'b1100000, "R6 release cycle", outs(), 7'b1100000);
    start_req = 1'b0;
    tick = 1'b0;
    @(negedge clk);
    check(outs() == 7'b1100100, "R6 interrupt clear pulse", outs(), 7'b1100100);
    @(negedge clk);
    check(outs() == 7'b1100010, "R7 protocol clock on", outs(), 7'b1100010);
    @(negedge clk);
    check(outs() == 7'b1100011, "R7 done", outs(), 7'b1100011);
    start_req = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(outs() == 7'b1100011, "R8 start after done ignored", outs(), 7'b1100011);
    end
    start_req = 1'b0;
  endtask

  task automatic t_async_abort();
    startup_cnt = 8'd40;
    tick = 1'b1;
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (6) @(negedge clk);
    check(usb_force_rst == 1'b1 && xcvr_pdn == 1'b0, "R9 mid wait",
          {xcvr_pdn, usb_force_rst}, 1);
    #2;
    rst_n = 1'b0;
    #1;
    check(outs() == RESET_OUTS, "R9 immediate return", outs(), RESET_OUTS);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(outs() == RESET_OUTS, "R9 R1 idle after abort", outs(), RESET_OUTS);
  endtask

  initial begin
    checks      = 0;
    errors      = 0;
    cycles      = 0;
    startup_cnt = '0;
    t_reset();
    t_sequence(5, 0, 1'b0);
    t_reset();
    t_sequence(0, 1, 1'b0);
    t_reset();
    t_sequence(12, 1, 1'b1);
    t_reset();
    t_sequence(1, 2, 1'b1);
    t_reset();
    t_async_abort();
    t_sequence(3, 2, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule